// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block is the processor-facing register file of a four-channel DMA controller. Software reaches it through a narrow 8-bit I/O port made of a 4-bit offset, write data, read data and single-cycle read and write strobes. Each channel holds a 16-bit start address and a 16-bit transfer count. Both are carried over the 8-bit port as two accesses to the same offset. A shared byte pointer chooses the low or high half of each access.

Writing a channel's address or count loads a base copy and a working copy. The base copy and the stored mode bits go to a separate transfer engine, together with the channel mask bits, the command byte and any software requests. The engine writes back the working address and count, and it pulses terminal-count flags. The processor reads those flags and the pending requests from the status register. Mask, mode and request changes are one-byte commands that carry the channel number in their two low bits. A master-clear command returns the control state to its idle values and leaves the channel contents alone.

Top module: `dma_regfile`

## Requirements
- R1: After reset the mask output is 4'b1111, the command output and the software requests are zero, the status register reads 0x00, and the byte pointer selects the low byte.
- R2: Channel n's address is at offset 2n and its count is at offset 2n+1. A write to either one loads the selected byte of both its base copy and its working copy. A read returns the selected byte of the working copy. The read data is valid combinationally in the same cycle as the read strobe.
- R3: Each completed read or write at offsets 0x0 to 0x7 toggles the byte pointer. The first access after the pointer is cleared uses bits 7:0 and the next uses bits 15:8. Any write to offset 0xC returns the pointer to the low byte.
- R4: The count is stored and exported exactly as written. By convention it is the number of transfers minus one, so 0x0000 means one transfer and 0xFFFF means 65536. When a working count of 0xFFFF is read back, software adds one and gets a residue of zero.
- R5: When the engine pulses the update strobe for channel n, the working address and count of that channel load the engine's values. The base copies do not change. A processor write to the same register in the same cycle wins.
- R6: A write to offset 0xA uses bits 1:0 to select the channel. Bit 2 set masks that channel and bit 2 clear unmasks it. The other mask bits keep their values.
- R7: A write to offset 0xE clears all four mask bits. A write to offset 0xF copies data bits 3:0 into the mask bits, where bit n is channel n.
- R8: A write to offset 0xB stores data bits 7:2 as channel (bits 1:0)'s 6-bit mode field. Mode field bit k is data bit k+2, so data bit 4 (auto-initialize) is field bit 2.
- R9: Status bits 3:0 are sticky terminal-count flags, one per channel, that the engine sets. Reading offset 0x8 clears them at the end of that read cycle, but a flag set in the same cycle stays set. Status bits 7:4 show the live OR of the engine's pending requests and the software requests.
- R10: A write to offset 0x9 uses bits 1:0 to select the channel. Bit 2 sets that channel's software request and bit 2 clear removes it.
- R11: Any write to offset 0xD sets all mask bits and clears the command byte, the terminal-count flags, the software requests and the byte pointer. Channel addresses, counts and modes keep their values.
- R12: A write to offset 0x8 stores the data byte as the command byte, which is exported to the engine.
- R13: Reads at offsets 0x9 through 0xF return 0x00 and do not move the byte pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| eng_base_addr | output | 64 | Base addresses, channel n at bits 16n+15:16n |
| eng_base_cnt | output | 64 | Base counts, channel n at bits 16n+15:16n |
| eng_mode | output | 24 | Mode fields, channel n at bits 6n+5:6n |
| eng_mask | output | 4 | Mask bits, bit n is channel n |
| eng_cmd | output | 8 | Command byte |
| eng_soft_req | output | 4 | Software requests, bit n is channel n |
| eng_upd | input | 4 | Per-channel working-copy update strobe |
| eng_cur_addr | input | 64 | Working addresses from the engine |
| eng_cur_cnt | input | 64 | Working counts from the engine |
| eng_tc | input | 4 | Terminal-count pulses |
| eng_req | input | 4 | Pending hardware requests |

## Verification
Read data is combinational. The bench therefore drives each read strobe after a falling edge and samples bus_rdata a quarter period later, in the same cycle. Every write, update strobe and terminal-count pulse reaches its register on the next rising edge. The exported outputs are checked just after that edge, and the register's effect on a later read is checked in the read that follows. Both pointer behaviours are checked by the byte order of consecutive reads: the toggle, and the clear on a clear-pointer or master-clear write. The clear-on-read of the status flags is checked by reading status twice in a row and expecting the flags only in the first result.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;

    localparam int NCH    = 4;
    localparam int DW     = 16;
    localparam int BW     = 8;
    localparam int AW     = 4;
    localparam int MODE_W = BW - 2;
    localparam int CH_W   = $clog2(NCH);

    typedef enum logic [AW-1:0] {
        OFF_CMD     = 4'h8,
        OFF_REQ     = 4'h9,
        OFF_SMASK   = 4'hA,
        OFF_MODE    = 4'hB,
        OFF_CLRPTR  = 4'hC,
        OFF_MCLR    = 4'hD,
        OFF_CLRMASK = 4'hE,
        OFF_ALLMASK = 4'hF
    } ctl_off_e;

    typedef struct packed {
        logic [CH_W-1:0] ch;
        logic            set;
    } chan_cmd_t;

    function automatic chan_cmd_t decode_chan_cmd(input logic [BW-1:0] b);
        chan_cmd_t c;
        c.ch  = b[CH_W-1:0];
        c.set = b[2];
        return c;
    endfunction

    function automatic logic is_chan_reg(input logic [AW-1:0] a);
        return ~a[AW-1];
    endfunction

    function automatic logic [DW-1:0] put_byte(input logic [DW-1:0] w,
                                               input logic hi,
                                               input logic [BW-1:0] b);
        logic [DW-1:0] r;
        r = w;
        if (hi) r[DW-1:BW] = b;
        else    r[BW-1:0]  = b;
        return r;
    endfunction

    function automatic logic [BW-1:0] get_byte(input logic [DW-1:0] w,
                                               input logic hi);
        return hi ? w[DW-1:BW] : w[BW-1:0];
    endfunction

endpackage

// File: rtl/dmarf_ptr.sv
module dmarf_ptr (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic toggle,
    output logic ptr_hi
);
    always_ff @(posedge clk) begin
        if (rst || clr) ptr_hi <= 1'b0;
        else if (toggle) ptr_hi <= ~ptr_hi;
    end
endmodule

// File: rtl/dmarf_chan.sv
module dmarf_chan
    import dmarf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              wr_mode,
    input  logic              hi,
    input  logic [BW-1:0]     wdata,
    input  logic              upd,
    input  logic [DW-1:0]     upd_addr,
    input  logic [DW-1:0]     upd_cnt,
    output logic [DW-1:0]     base_addr,
    output logic [DW-1:0]     base_cnt,
    output logic [DW-1:0]     cur_addr,
    output logic [DW-1:0]     cur_cnt,
    output logic [MODE_W-1:0] mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            mode      <= '0;
        end else begin
            if (wr_addr) begin
                base_addr <= put_byte(base_addr, hi, wdata);
                cur_addr  <= put_byte(cur_addr, hi, wdata);
            end else if (upd) begin
                cur_addr  <= upd_addr;
            end
            if (wr_cnt) begin
                base_cnt  <= put_byte(base_cnt, hi, wdata);
                cur_cnt   <= put_byte(cur_cnt, hi, wdata);
            end else if (upd) begin
                cur_cnt   <= upd_cnt;
            end
            if (wr_mode) mode <= wdata[BW-1:2];
        end
    end
endmodule

// File: rtl/dmarf_ctrl.sv
module dmarf_ctrl
    import dmarf_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           wr,
    input  logic           rd,
    input  logic [AW-1:0]  addr,
    input  logic [BW-1:0]  wdata,
    input  logic [NCH-1:0] tc_in,
    input  logic [NCH-1:0] req_in,
    output logic [NCH-1:0] mask,
    output logic [BW-1:0]  cmd,
    output logic [NCH-1:0] sw_req,
    output logic [NCH-1:0] tc_flags,
    output logic [BW-1:0]  status
);
    chan_cmd_t cc;
    logic      mclr;
    logic      st_rd;

    assign cc    = decode_chan_cmd(wdata);
    assign mclr  = wr && (addr == OFF_MCLR);
    assign st_rd = rd && (addr == OFF_CMD);

    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            mask     <= '1;
            cmd      <= '0;
            sw_req   <= '0;
            tc_flags <= '0;
        end else begin
            tc_flags <= (st_rd ? '0 : tc_flags) | tc_in;
            if (wr) begin
                case (addr)
                    OFF_CMD:     cmd <= wdata;
                    OFF_REQ:     sw_req[cc.ch] <= cc.set;
                    OFF_SMASK:   mask[cc.ch] <= cc.set;
                    OFF_CLRMASK: mask <= '0;
                    OFF_ALLMASK: mask <= wdata[NCH-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign status = {req_in | sw_req, tc_flags};
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dmarf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [AW-1:0]         bus_addr,
    input  logic [BW-1:0]         bus_wdata,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    output logic [BW-1:0]         bus_rdata,
    output logic [NCH*DW-1:0]     eng_base_addr,
    output logic [NCH*DW-1:0]     eng_base_cnt,
    output logic [NCH*MODE_W-1:0] eng_mode,
    output logic [NCH-1:0]        eng_mask,
    output logic [BW-1:0]         eng_cmd,
    output logic [NCH-1:0]        eng_soft_req,
    input  logic [NCH-1:0]        eng_upd,
    input  logic [NCH*DW-1:0]     eng_cur_addr,
    input  logic [NCH*DW-1:0]     eng_cur_cnt,
    input  logic [NCH-1:0]        eng_tc,
    input  logic [NCH-1:0]        eng_req
);
    logic                  ptr_hi;
    logic                  chan_acc;
    logic                  ptr_clr;
    logic [CH_W-1:0]       sel_ch;
    logic [NCH-1:0]        tc_flags;
    logic [BW-1:0]         status;
    logic [DW-1:0]         cur_addr [NCH];
    logic [DW-1:0]         cur_cnt  [NCH];
    chan_cmd_t             mode_cc;

    assign chan_acc = (bus_wr || bus_rd) && is_chan_reg(bus_addr);
    assign ptr_clr  = bus_wr && (bus_addr == OFF_CLRPTR || bus_addr == OFF_MCLR);
    assign sel_ch   = bus_addr[CH_W:1];
    assign mode_cc  = decode_chan_cmd(bus_wdata);

    dmarf_ptr u_ptr (
        .clk    (clk),
        .rst    (rst),
        .clr    (ptr_clr),
        .toggle (chan_acc),
        .ptr_hi (ptr_hi)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic hit;
        assign hit = bus_wr && is_chan_reg(bus_addr) && (sel_ch == CH_W'(n));
        dmarf_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_addr   (hit && !bus_addr[0]),
            .wr_cnt    (hit && bus_addr[0]),
            .wr_mode   (bus_wr && bus_addr == OFF_MODE && mode_cc.ch == CH_W'(n)),
            .hi        (ptr_hi),
            .wdata     (bus_wdata),
            .upd       (eng_upd[n]),
            .upd_addr  (eng_cur_addr[n*DW +: DW]),
            .upd_cnt   (eng_cur_cnt[n*DW +: DW]),
            .base_addr (eng_base_addr[n*DW +: DW]),
            .base_cnt  (eng_base_cnt[n*DW +: DW]),
            .cur_addr  (cur_addr[n]),
            .cur_cnt   (cur_cnt[n]),
            .mode      (eng_mode[n*MODE_W +: MODE_W])
        );
    end

    dmarf_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .tc_in    (eng_tc),
        .req_in   (eng_req),
        .mask     (eng_mask),
        .cmd      (eng_cmd),
        .sw_req   (eng_soft_req),
        .tc_flags (tc_flags),
        .status   (status)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (is_chan_reg(bus_addr))
                bus_rdata = get_byte(bus_addr[0] ? cur_cnt[sel_ch] : cur_addr[sel_ch], ptr_hi);
            else if (bus_addr == OFF_CMD)
                bus_rdata = status;
        end
    end
endmodule

// File: rtl/dmarf_checker.sv
module dmarf_checker
    import dmarf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [AW-1:0]     bus_addr,
    input logic [BW-1:0]     bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              ptr_hi,
    input logic [NCH-1:0]    tc_flags,
    input logic [NCH-1:0]    eng_mask,
    input logic [BW-1:0]     eng_cmd,
    input logic [NCH-1:0]    eng_soft_req,
    input logic [NCH*DW-1:0] eng_base_addr,
    input logic [NCH*DW-1:0] eng_base_cnt
);
    // R3: clear-pointer write leaves the pointer on the low byte
    a_r3_ptr_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 4'hC) |=> !ptr_hi);

    // R3: control-offset reads leave the pointer still (R13)
    a_r13_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr[3]) |=> $stable(ptr_hi));

    // R6: single-mask set command masks the selected channel
    a_r6_mask_set: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 4'hA && bus_wdata[2]) |=> eng_mask[$past(bus_wdata[1:0])]);

    // R11: master clear state
    a_r11_mclr: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 4'hD) |=> (eng_mask == '1 && eng_cmd == '0 && eng_soft_req == '0 && tc_flags == '0));

    // R5: base copies move only on processor writes
    a_r5_base_stable: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> ($stable(eng_base_addr) && $stable(eng_base_cnt)));

    // R9: flags stay set unless status is read or master clear
    a_r9_tc_sticky: assert property (@(posedge clk) disable iff (rst)
        (!(bus_rd && bus_addr == 4'h8) && !(bus_wr && bus_addr == 4'hD))
        |=> ((tc_flags & $past(tc_flags)) == $past(tc_flags)));
endmodule

bind dma_regfile dmarf_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .ptr_hi        (ptr_hi),
    .tc_flags      (tc_flags),
    .eng_mask      (eng_mask),
    .eng_cmd       (eng_cmd),
    .eng_soft_req  (eng_soft_req),
    .eng_base_addr (eng_base_addr),
    .eng_base_cnt  (eng_base_cnt)
);

// File: tb/dma_regfile_test.sv
module dma_regfile_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_wr;
    logic        bus_rd;
    logic [7:0]  bus_rdata;
    logic [63:0] eng_base_addr;
    logic [63:0] eng_base_cnt;
    logic [23:0] eng_mode;
    logic [3:0]  eng_mask;
    logic [7:0]  eng_cmd;
    logic [3:0]  eng_soft_req;
    logic [3:0]  eng_upd;
    logic [63:0] eng_cur_addr;
    logic [63:0] eng_cur_cnt;
    logic [3:0]  eng_tc;
    logic [3:0]  eng_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    dma_regfile uut (.*);

    // {is_read, offset, data, expected read}
    localparam int NV = 22;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 4'hC, 8'h00, 8'h00},
        {1'b0, 4'h0, 8'h34, 8'h00},
        {1'b0, 4'h0, 8'h12, 8'h00},
        {1'b0, 4'h1, 8'hFF, 8'h00},
        {1'b0, 4'h1, 8'h00, 8'h00},
        {1'b0, 4'h6, 8'hCD, 8'h00},
        {1'b0, 4'h6, 8'hAB, 8'h00},
        {1'b1, 4'h0, 8'h00, 8'h34},
        {1'b1, 4'h0, 8'h00, 8'h12},
        {1'b1, 4'h1, 8'h00, 8'hFF},
        {1'b1, 4'h1, 8'h00, 8'h00},
        {1'b1, 4'h6, 8'h00, 8'hCD},
        {1'b1, 4'h6, 8'h00, 8'hAB},
        {1'b0, 4'h0, 8'h55, 8'h00},
        {1'b1, 4'h0, 8'h00, 8'h12},
        {1'b1, 4'h0, 8'h00, 8'h55},
        {1'b0, 4'hB, 8'h49, 8'h00},
        {1'b1, 4'hA, 8'h00, 8'h00},
        {1'b1, 4'hD, 8'h00, 8'h00},
        {1'b1, 4'hE, 8'h00, 8'h00},
        {1'b0, 4'hC, 8'h00, 8'h00},
        {1'b1, 4'h0, 8'h00, 8'h55}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(input logic rd, input logic [3:0] a, input logic [7:0] d,
                          output logic [7:0] q);
        @(negedge clk);
        bus_rd = rd; bus_wr = ~rd; bus_addr = a; bus_wdata = d;
        #5 q = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        logic [7:0] q;
        access(1'b0, a, d, q);
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] e);
        logic [7:0] q;
        access(1'b1, a, 8'h00, q);
        check(req, 64'(q), 64'(e));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        eng_upd = '0; eng_cur_addr = '0; eng_cur_cnt = '0; eng_tc = '0; eng_req = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check("R1 mask", 64'(eng_mask), 64'hF);
        check("R1 cmd", 64'(eng_cmd), 64'h0);
        check("R1 softreq", 64'(eng_soft_req), 64'h0);
        rd_chk("R1 status", 4'h8, 8'h00);
        rd_chk("R1 ptr low", 4'h0, 8'h00);
        wr(4'hC, 8'h00);

        // R2 R3 R4 R13 table
        for (int i = 0; i < NV; i++) begin
            logic [7:0] q;
            access(VEC[i][20], VEC[i][19:16], VEC[i][15:8], q);
            if (VEC[i][20]) check("R2/R3/R4/R13 vector", 64'(q), 64'(VEC[i][7:0]));
        end
        check("R2 base addr ch0", 64'(eng_base_addr[15:0]), 64'h1255);
        check("R4 base cnt ch0", 64'(eng_base_cnt[15:0]), 64'h00FF);
        check("R2 base addr ch3", 64'(eng_base_addr[63:48]), 64'hABCD);
        check("R8 mode ch1", 64'(eng_mode[11:6]), 64'h12);
        check("R8 mode ch0 untouched", 64'(eng_mode[5:0]), 64'h0);

        // R6 R7 masks
        wr(4'hA, 8'h00);
        check("R6 unmask ch0", 64'(eng_mask), 64'hE);
        wr(4'hA, 8'h02);
        check("R6 unmask ch2", 64'(eng_mask), 64'hA);
        wr(4'hA, 8'h04);
        check("R6 mask ch0", 64'(eng_mask), 64'hB);
        wr(4'hE, 8'hFF);
        check("R7 clear all", 64'(eng_mask), 64'h0);
        wr(4'hF, 8'h05);
        check("R7 write all", 64'(eng_mask), 64'h5);

        // R5 engine update, R4 residue readback
        wr(4'hC, 8'h00);
        @(negedge clk);
        eng_cur_addr[15:0] = 16'h8000; eng_cur_cnt[15:0] = 16'hFFFF; eng_upd = 4'b0001;
        @(negedge clk);
        eng_upd = '0;
        rd_chk("R5 cur addr lo", 4'h0, 8'h00);
        rd_chk("R5 cur addr hi", 4'h0, 8'h80);
        rd_chk("R4 residue lo", 4'h1, 8'hFF);
        rd_chk("R4 residue hi", 4'h1, 8'hFF);
        check("R5 base addr kept", 64'(eng_base_addr[15:0]), 64'h1255);
        check("R5 base cnt kept", 64'(eng_base_cnt[15:0]), 64'h00FF);

        // R9 status flags
        @(negedge clk);
        eng_req = 4'b0001; eng_tc = 4'b0100;
        @(negedge clk);
        eng_tc = '0;
        rd_chk("R9 status first", 4'h8, 8'h14);
        rd_chk("R9 status cleared", 4'h8, 8'h10);
        eng_req = '0;

        // R10 software request
        wr(4'h9, 8'h07);
        check("R10 soft req", 64'(eng_soft_req), 64'h8);
        rd_chk("R10 status req", 4'h8, 8'h80);

        // R12 command
        wr(4'h8, 8'hA5);
        check("R12 cmd", 64'(eng_cmd), 64'hA5);

        // R11 master clear
        @(negedge clk);
        eng_tc = 4'b0010;
        @(negedge clk);
        eng_tc = '0;
        wr(4'h2, 8'h11);
        wr(4'hD, 8'h00);
        check("R11 mask", 64'(eng_mask), 64'hF);
        check("R11 cmd", 64'(eng_cmd), 64'h0);
        check("R11 soft req", 64'(eng_soft_req), 64'h0);
        rd_chk("R11 status", 4'h8, 8'h00);
        rd_chk("R11 ptr low", 4'h0, 8'h00);
        rd_chk("R11 addr kept", 4'h0, 8'h80);
        check("R11 mode kept", 64'(eng_mode[11:6]), 64'h12);

        finish_run();
    end
endmodule